// File: doc/BRIEF.md
# Threshold Packet FIFO with Overflow Termination

This block is a packet buffer placed between a packet source and a downstream packet interface. Each input word carries start and end markers. The buffer warns the source with a backpressure signal when it fills past a first level. The signal has hysteresis, so it is released only after the buffer has drained well below that level.

A second, higher level marks overflow. The word that reaches this level is stored as the last word of its packet, with an error flag. Input words of that truncated packet are then thrown away until the packet's own end marker. The next packet is accepted normally. The downstream side therefore always receives complete packets. A truncated packet arrives closed and marked with the error flag.

Overflow is reported on a sticky status bit, which is cleared with a write-one-to-clear input. Writes that arrive while the buffer is completely full are dropped and counted. The capacity is a power of two, and all three levels are derived from it: backpressure on at 5/8, backpressure off below 1/2, overflow at 3/4.

Top module: `pkt_thresh_fifo`

## Requirements
- R1: Accepted words leave in arrival order. A word written into an empty buffer is presented on the output with `out_valid` high one clock edge after it is accepted. A word is removed on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the presented word holds.
- R2: `bp` is high after any edge that leaves the occupancy at or above DEPTH*5/8 (10 for DEPTH 16).
- R3: `bp` goes low after an edge that leaves the occupancy below DEPTH/2 (8 for DEPTH 16). Between the two levels, `bp` keeps its previous value.
- R4: An overflow event is an accepted write that raises the occupancy from DEPTH*3/4-1 to DEPTH*3/4 (11 to 12 for DEPTH 16), with no read on the same edge. The word that causes the event is stored with its end marker forced high and its error flag high.
- R5: If the overflow word did not carry an end marker, the following input words are discarded. The discard runs up to and including the next word whose `in_eop` is high. The word after that is accepted normally. If the overflow word did carry an end marker, nothing is discarded.
- R6: `ovf_flag` goes high on the edge of an overflow event and stays high until an edge where `ovf_clr` is high. If an event and `ovf_clr` occur on the same edge, the flag is set.
- R7: A write that arrives while the occupancy equals DEPTH is not stored, and it increments `drop_cnt`. Words discarded under R5 are not counted.
- R8: `drop_cnt` saturates at 2^DROP_W-1 (255 by default).
- R9: After reset, `out_valid`, `bp`, `ovf_flag` and `drop_cnt` are all zero, and the next input word is accepted.
- R10: `out_sop` and `out_eop` reproduce the input markers of each word, except for the end marker forced under R4. `out_err` is high only on a word that caused an overflow event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_data | input | DW | Input word data |
| in_sop | input | 1 | Input word starts a packet |
| in_eop | input | 1 | Input word ends a packet |
| out_ready | input | 1 | Downstream takes the presented word |
| out_valid | output | 1 | Output word present |
| out_data | output | DW | Output word data |
| out_sop | output | 1 | Output word starts a packet |
| out_eop | output | 1 | Output word ends a packet |
| out_err | output | 1 | Output word closes a packet cut by overflow |
| bp | output | 1 | Backpressure to the source |
| ovf_flag | output | 1 | Sticky overflow status |
| ovf_clr | input | 1 | Write-one-to-clear for `ovf_flag` |
| drop_cnt | output | DROP_W | Saturating count of writes refused at full |

## Verification
An accepted word reaches the output one edge after the write. `bp`, `ovf_flag` and `drop_cnt` change on the same edge as the write or read that moves the occupancy. None of these results is delayed by a further cycle.

The bench applies each set of inputs at a falling edge. It advances its arithmetic model with those same inputs. At the next falling edge it compares every output against the model, so each result is sampled in the first cycle in which it is due.

The sweeps cover:
- stalled fills that cross each level;
- overflow on a middle word and on an end word;
- a clear on the same edge as an event;
- a long run of refused writes that reaches saturation;
- a long sequence of random valid and ready patterns.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

    // Per-word side information carried next to the data.
    typedef struct packed {
        logic err;
        logic eop;
        logic sop;
    } wtag_t;

    // Write-side admission state.
    typedef enum logic {
        WR_ADMIT = 1'b0,
        WR_SKIP  = 1'b1
    } wr_mode_e;

    function automatic int unsigned lvl_bp_on(input int unsigned depth);
        return (depth * 5) / 8;
    endfunction

    function automatic int unsigned lvl_bp_off(input int unsigned depth);
        return depth / 2;
    endfunction

    function automatic int unsigned lvl_ovf(input int unsigned depth);
        return (depth * 3) / 4;
    endfunction

endpackage

// File: rtl/tpf_store.sv
module tpf_store
    import tpf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  wtag_t         wr_tag,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output wtag_t         rd_tag,
    output logic [AW:0]   occ,
    output logic [AW:0]   occ_nxt,
    output logic          empty,
    output logic          full
);

    typedef struct packed {
        wtag_t         tag;
        logic [DW-1:0] data;
    } slot_t;

    slot_t         mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;

    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

    assign empty   = (occ == '0);
    assign full    = (occ == FULL_LVL);
    assign occ_nxt = occ + (AW+1)'(wr_en) - (AW+1)'(rd_en);
    assign rd_data = mem[rp].data;
    assign rd_tag  = mem[rp].tag;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wp] <= '{tag: wr_tag, data: wr_data};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            occ <= '0;
        end else begin
            if (wr_en) wp <= wp + AW'(1);
            if (rd_en) rp <= rp + AW'(1);
            occ <= occ_nxt;
        end
    end

endmodule

// File: rtl/tpf_admit.sv
module tpf_admit
    import tpf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DROP_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              full,
    input  logic              rd_en,
    input  logic [AW:0]       occ,
    input  logic              ovf_clr,
    output logic              wr_en,
    output wtag_t             wr_tag,
    output logic              ovf_flag,
    output logic [DROP_W-1:0] drop_cnt
);

    localparam logic [AW:0] OVF_M1 = (AW+1)'(lvl_ovf(DEPTH) - 1);

    wr_mode_e mode;
    logic     ovf_evt;
    logic     refuse;

    assign wr_en   = in_valid && (mode == WR_ADMIT) && !full;
    assign refuse  = in_valid && (mode == WR_ADMIT) && full;
    assign ovf_evt = wr_en && !rd_en && (occ == OVF_M1);
    assign wr_tag  = '{err: ovf_evt, eop: in_eop | ovf_evt, sop: in_sop};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= WR_ADMIT;
            ovf_flag <= 1'b0;
            drop_cnt <= '0;
        end else begin
            if (in_valid && (mode == WR_SKIP) && in_eop) begin
                mode <= WR_ADMIT;
            end else if (ovf_evt && !in_eop) begin
                mode <= WR_SKIP;
            end

            if (ovf_evt) begin
                ovf_flag <= 1'b1;
            end else if (ovf_clr) begin
                ovf_flag <= 1'b0;
            end

            if (refuse && (drop_cnt != '1)) begin
                drop_cnt <= drop_cnt + DROP_W'(1);
            end
        end
    end

endmodule

// File: rtl/tpf_hyst.sv
module tpf_hyst
    import tpf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [AW:0] occ_nxt,
    output logic        bp
);

    localparam logic [AW:0] ON_LVL  = (AW+1)'(lvl_bp_on(DEPTH));
    localparam logic [AW:0] OFF_LVL = (AW+1)'(lvl_bp_off(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            bp <= 1'b0;
        end else if (occ_nxt >= ON_LVL) begin
            bp <= 1'b1;
        end else if (occ_nxt < OFF_LVL) begin
            bp <= 1'b0;
        end
    end

endmodule

// File: rtl/pkt_thresh_fifo.sv
module pkt_thresh_fifo
    import tpf_pkg::*;
#(
    parameter int DW     = 8,
    parameter int DEPTH  = 16,
    parameter int DROP_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DW-1:0]     in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DW-1:0]     out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_err,
    output logic              bp,
    output logic              ovf_flag,
    input  logic              ovf_clr,
    output logic [DROP_W-1:0] drop_cnt
);

    logic        wr_en;
    logic        rd_en;
    wtag_t       wr_tag;
    wtag_t       rd_tag;
    logic [AW:0] occ;
    logic [AW:0] occ_nxt;
    logic        empty;
    logic        full;

    assign out_valid = !empty;
    assign rd_en     = out_valid && out_ready;
    assign out_sop   = rd_tag.sop;
    assign out_eop   = rd_tag.eop;
    assign out_err   = rd_tag.err;

    tpf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (in_data),
        .wr_tag  (wr_tag),
        .rd_en   (rd_en),
        .rd_data (out_data),
        .rd_tag  (rd_tag),
        .occ     (occ),
        .occ_nxt (occ_nxt),
        .empty   (empty),
        .full    (full)
    );

    tpf_admit #(.DEPTH(DEPTH), .DROP_W(DROP_W)) u_admit (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .full     (full),
        .rd_en    (rd_en),
        .occ      (occ),
        .ovf_clr  (ovf_clr),
        .wr_en    (wr_en),
        .wr_tag   (wr_tag),
        .ovf_flag (ovf_flag),
        .drop_cnt (drop_cnt)
    );

    tpf_hyst #(.DEPTH(DEPTH)) u_hyst (
        .clk     (clk),
        .rst     (rst),
        .occ_nxt (occ_nxt),
        .bp      (bp)
    );

endmodule

// File: rtl/tpf_checker.sv
module tpf_checker
    import tpf_pkg::*;
#(
    parameter int DW     = 8,
    parameter int DEPTH  = 16,
    parameter int DROP_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DW-1:0]     out_data,
    input logic              out_eop,
    input logic              out_err,
    input logic              bp,
    input logic              ovf_flag,
    input logic              ovf_clr,
    input logic [DROP_W-1:0] drop_cnt,
    input logic [AW:0]       occ
);

    localparam logic [AW:0] ON_LVL   = (AW+1)'(lvl_bp_on(DEPTH));
    localparam logic [AW:0] OFF_LVL  = (AW+1)'(lvl_bp_off(DEPTH));
    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

    a_r1_hold_presented: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r2_bp_at_high: assert property (@(posedge clk) disable iff (rst)
        (occ >= ON_LVL) |-> bp);

    a_r3_bp_below_low: assert property (@(posedge clk) disable iff (rst)
        (occ < OFF_LVL) |-> !bp);

    a_r4_err_closes: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |-> out_eop);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    a_r7_never_overfilled: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL_LVL);

    a_r8_drop_saturates: assert property (@(posedge clk) disable iff (rst)
        (drop_cnt == '1) |=> (drop_cnt == '1));

endmodule

bind pkt_thresh_fifo tpf_checker #(.DW(DW), .DEPTH(DEPTH), .DROP_W(DROP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_eop   (out_eop),
    .out_err   (out_err),
    .bp        (bp),
    .ovf_flag  (ovf_flag),
    .ovf_clr   (ovf_clr),
    .drop_cnt  (drop_cnt),
    .occ       (occ)
);

// File: tb/test_pkt_thresh_fifo.sv
`timescale 1ns/1ps
module test_pkt_thresh_fifo;

    localparam int DW = 8, DEPTH = 16, DROP_W = 8;
    localparam int ON_L = 10, OFF_L = 8, OVF_L = 12, DMAX = 255;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 0, in_sop = 0, in_eop = 0, out_ready = 0, ovf_clr = 0;
    logic [DW-1:0] in_data = '0;
    logic out_valid, out_sop, out_eop, out_err, bp, ovf_flag;
    logic [DW-1:0] out_data;
    logic [DROP_W-1:0] drop_cnt;

    always #10 clk = ~clk;

    pkt_thresh_fifo #(.DW(DW), .DEPTH(DEPTH), .DROP_W(DROP_W)) i_pkt_thresh_fifo (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .out_err(out_err), .bp(bp), .ovf_flag(ovf_flag),
        .ovf_clr(ovf_clr), .drop_cnt(drop_cnt)
    );

    int checks = 0, errors = 0;

    // Reference model state
    logic [10:0] mq[$];          // {err, eop, sop, data}
    bit m_skip = 0, m_bp = 0, m_ovf = 0;
    int m_drop = 0;
    logic [7:0] seq = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int cnt = mq.size();
        chk("R1 out_valid", int'(out_valid), int'(cnt != 0));
        if (cnt != 0) begin
            chk("R1 out_data order", int'(out_data), int'(mq[0][7:0]));
            chk("R10 out_sop", int'(out_sop), int'(mq[0][8]));
            chk("R4 out_eop", int'(out_eop), int'(mq[0][9]));
            chk("R10 out_err", int'(out_err), int'(mq[0][10]));
        end
        if (m_bp) chk("R2 bp", int'(bp), 1);
        else      chk("R3 bp", int'(bp), 0);
        chk("R6 ovf_flag", int'(ovf_flag), int'(m_ovf));
        chk("R7 R8 drop_cnt", int'(drop_cnt), m_drop);
    endtask

    // One cycle: compare outputs, apply inputs, advance model.
    task automatic step(input bit v, input bit s, input bit e, input bit r, input bit c);
        int cnt;
        bit rd, wr, evt;
        @(negedge clk);
        compare_all();
        seq = seq + 8'd1;
        in_valid = v; in_sop = s; in_eop = e; out_ready = r; ovf_clr = c;
        in_data = seq;
        cnt = mq.size();
        rd = (cnt > 0) && r;
        wr = v && !m_skip && (cnt < DEPTH);
        evt = wr && !rd && (cnt == OVF_L - 1);
        if (v && m_skip) begin
            if (e) m_skip = 0;
        end else if (v && cnt == DEPTH && m_drop < DMAX) begin
            m_drop++;
        end
        if (rd) void'(mq.pop_front());
        if (wr) mq.push_back({evt, e | evt, s, seq});
        if (evt && !e) m_skip = 1;
        if (evt) m_ovf = 1; else if (c) m_ovf = 0;
        cnt = mq.size();
        if (cnt >= ON_L) m_bp = 1; else if (cnt < OFF_L) m_bp = 0;
    endtask

    task automatic send_pkt(input int len, input bit r);
        for (int i = 0; i < len; i++) step(1, i == 0, i == len - 1, r, 0);
    endtask

    task automatic idle(input int n, input bit r);
        for (int i = 0; i < n; i++) step(0, 0, 0, r, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; in_valid = 0; out_ready = 0; ovf_clr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        mq.delete(); m_skip = 0; m_bp = 0; m_ovf = 0; m_drop = 0;
        #1;
        chk("R9 reset out_valid", int'(out_valid), 0);
        chk("R9 reset bp", int'(bp), 0);
        chk("R9 reset ovf_flag", int'(ovf_flag), 0);
        chk("R9 reset drop_cnt", int'(drop_cnt), 0);
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R9: first word after reset accepted; R1 pass-through, one-edge latency
        send_pkt(1, 1); idle(2, 1);
        send_pkt(2, 1); send_pkt(5, 1); idle(3, 1);
        // R1 stall hold, R2 rise at 10, R3 hysteresis on drain
        send_pkt(9, 0); idle(2, 0);
        send_pkt(1, 0); idle(2, 0);
        idle(12, 1);
        // R4 R5: overflow on a middle word, tail discarded, next packets admitted
        send_pkt(15, 0);
        send_pkt(3, 0);
        // R7: two refused writes at full
        send_pkt(3, 0); idle(2, 0);
        // R6: clear the sticky flag
        step(0, 0, 0, 0, 1); idle(2, 0);
        idle(20, 1);
        // R4 R5: overflow on an end word, nothing discarded
        send_pkt(12, 0); send_pkt(2, 0); idle(20, 1);
        // R6: clear on the same edge as an event, set wins
        for (int i = 0; i < 12; i++) step(1, i == 0, i == 11, 0, i == 11);
        idle(2, 0); step(0, 0, 0, 0, 1); idle(20, 1);
        // R8: fill, then long run of refused writes to saturation
        send_pkt(12, 0); send_pkt(4, 0);
        for (int i = 0; i < 300; i++) step(1, 1, 1, 0, 0);
        idle(20, 1);
        // Random sweep of valid/ready patterns
        do_reset();
        begin
            int pos = 0, len = 3;
            for (int n = 0; n < 6000; n++) begin
                bit v = ($urandom % 4) != 0;
                bit r = ($urandom % 3) == 0;
                bit c = ($urandom % 50) == 0;
                if (v) begin
                    step(1, pos == 0, pos == len - 1, r, c);
                    pos++;
                    if (pos == len) begin pos = 0; len = 1 + int'($urandom % 9); end
                end else begin
                    step(0, 0, 0, r, c);
                end
            end
        end
        idle(30, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule